// File: doc/BRIEF.md
# Dual-Mode Floppy Controller Register Front End

This block is the bus-facing register layer of a floppy disk controller. It answers a simple memory-mapped slave interface with an address, a write byte, a read byte, and separate write and read strobes. Out of reset it runs in a legacy personality. In that mode the address alone carries the information: each access sets or clears one of eight control latches. When two particular latches are both high, a write also deposits its byte into a data holder or a mode holder.

Writes that reach the mode holder are also watched by an unlock detector. After a fixed four-byte sequence, the block switches for good into an extended personality with a direct register map: a phase register, a mode register with separate bit-clear and bit-set ports, and a handshake status that reports a sense bit for one phase pattern. Only reset returns the block to legacy mode.

The latches, the two holders and the extended mode bits are driven out as ports so that the drive-side logic can use them.

Top module: `flop_regfront`

## Requirements
- R1: The register index is address bits [12:9]. Address bits [8:0] have no effect on any access, so the block decodes a 0x2000-byte window.
- R2: In legacy mode, every write or read sets latch number index[3:1] to the value of index[0], on the clock edge where the strobe is high. On `ctlLatches`, bit 0 to bit 3 are phase0 to phase3, bit 4 is motor, bit 5 is drive select, bit 6 is Q6 and bit 7 is Q7.
- R3: A legacy write whose latch state, after that access's own latch update, has Q6 and Q7 both set stores `wrData` as follows:
  - into `holdData` if motor is set;
  - into `holdMode` if motor is clear.
  
  A legacy write with Q6 or Q7 clear stores into neither holder.
- R4: Each byte stored into `holdMode` advances the unlock detector only if it matches the expected byte of the sequence 0x57, 0x17, 0x57, 0x57. A byte that does not match leaves the detector at its current step.
- R5: The fourth matching byte sets `extMode` from the clock edge of that write onward, and the detector returns to step 0. `extMode` never falls except at reset.
- R6: In legacy mode, `rdData` is 0 for every index.
- R7: In extended mode, a write selects its action by index:
  - index 4 loads the phase register;
  - index 6 clears the `modeBits` bits that are set in `wrData`;
  - index 7 sets the `modeBits` bits that are set in `wrData`;
  - every other index (including 0 to 3 and 5) changes nothing.
  
  No access in extended mode alters `ctlLatches`, `holdData` or `holdMode`.
- R8: In extended mode, `rdData` depends on the index:
  - index 12 returns the phase register;
  - index 15 returns 0x08 when the phase register equals 0x77, and 0 otherwise;
  - every other index returns 0.
- R9: Reset (`rstN` low) returns the block to the following state:
  - legacy mode;
  - detector at step 0;
  - all latches, both holders, the phase register and `modeBits` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 13 | Byte address within the window |
| wrData | input | 8 | Write byte |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (commits latch side effects in legacy mode) |
| rdData | output | 8 | Combinational read byte |
| extMode | output | 1 | High once the extended personality is active |
| ctlLatches | output | 8 | The eight legacy control latches |
| holdData | output | 8 | Legacy data holder |
| holdMode | output | 8 | Legacy mode holder |
| modeBits | output | 8 | Extended mode register |

## Verification
The assertions assume that the bus never raises `wrEn` and `rdEn` in the same cycle. They also assume that address and write data hold steady across each edge where a strobe is high. The bench drives every access as a single-strobe, one-cycle pulse, changed only at the falling clock edge, so both assumptions always hold. The assertions also assume that a reset is the only way out of extended mode. The bench leaves extended mode only through an explicit reset pulse, and it re-checks the reset values after that pulse.

// File: rtl/flopfront_pkg.sv
package flopfront_pkg;

  localparam int DATA_W     = 8;
  localparam int NUM_LATCH  = 8;
  localparam int LAT_SEL_W  = $clog2(NUM_LATCH);
  localparam int UNLOCK_LEN = 4;
  localparam int STEP_W     = $clog2(UNLOCK_LEN);

  localparam int LAT_MOTOR = 4;
  localparam int LAT_Q6    = 6;
  localparam int LAT_Q7    = 7;

  localparam int IDX_PHASE_WR = 4;
  localparam int IDX_MODE_CLR = 6;
  localparam int IDX_MODE_SET = 7;
  localparam int IDX_PHASE_RD = 12;
  localparam int IDX_HSHK_RD  = 15;

  localparam logic [DATA_W-1:0] PHASE_PRESENT = 8'h77;
  localparam logic [DATA_W-1:0] SENSE_BIT     = 8'h08;

  typedef struct packed {
    logic                 latchWe;
    logic [LAT_SEL_W-1:0] latchSel;
    logic                 latchVal;
    logic                 dataWe;
    logic                 modeWe;
    logic                 phaseWe;
    logic                 clrWe;
    logic                 setWe;
  } strobe_t;

  function automatic logic [DATA_W-1:0] unlockByte(input logic [STEP_W-1:0] step);
    return (step == STEP_W'(1)) ? 8'h17 : 8'h57;
  endfunction

endpackage

// File: rtl/frontCtrl.sv
module frontCtrl
  import flopfront_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [NUM_LATCH-1:0] latchQ,
  output strobe_t              stb,
  output logic                 extMode
);

  logic [STEP_W-1:0]    step;
  logic [NUM_LATCH-1:0] latchEff;
  logic                 access;

  assign access = wrEn | rdEn;

  always_comb begin
    stb      = '0;
    latchEff = latchQ;
    if (!extMode) begin
      stb.latchWe  = access;
      stb.latchSel = idx[LAT_SEL_W:1];
      stb.latchVal = idx[0];
      if (access) latchEff[idx[LAT_SEL_W:1]] = idx[0];
      if (wrEn && latchEff[LAT_Q6] && latchEff[LAT_Q7]) begin
        if (latchEff[LAT_MOTOR]) stb.dataWe = 1'b1;
        else                     stb.modeWe = 1'b1;
      end
    end else if (wrEn) begin
      stb.phaseWe = (idx == IDX_W'(IDX_PHASE_WR));
      stb.clrWe   = (idx == IDX_W'(IDX_MODE_CLR));
      stb.setWe   = (idx == IDX_W'(IDX_MODE_SET));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step    <= '0;
      extMode <= 1'b0;
    end else if (stb.modeWe && wrData == unlockByte(step)) begin
      if (step == STEP_W'(UNLOCK_LEN-1)) begin
        step    <= '0;
        extMode <= 1'b1;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    extMode |=> extMode);

  p_unlock_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extMode) |-> ($past(stb.modeWe) && $past(wrData) == 8'h57));

  p_one_action_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.dataWe, stb.modeWe, stb.phaseWe, stb.clrWe, stb.setWe}));

  p_ext_no_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    extMode |-> !stb.latchWe);

endmodule

// File: rtl/frontData.sv
module frontData
  import flopfront_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 extMode,
  output logic [NUM_LATCH-1:0] latchQ,
  output logic [DATA_W-1:0]    holdData,
  output logic [DATA_W-1:0]    holdMode,
  output logic [DATA_W-1:0]    modeBits,
  output logic [DATA_W-1:0]    rdData
);

  logic [DATA_W-1:0] phase;

  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        latchQ[g] <= 1'b0;
      else if (stb.latchWe && stb.latchSel == LAT_SEL_W'(g))
        latchQ[g] <= stb.latchVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      holdMode <= '0;
      phase    <= '0;
      modeBits <= '0;
    end else begin
      if (stb.dataWe)  holdData <= wrData;
      if (stb.modeWe)  holdMode <= wrData;
      if (stb.phaseWe) phase    <= wrData;
      if (stb.clrWe)   modeBits <= modeBits & ~wrData;
      else if (stb.setWe) modeBits <= modeBits | wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (extMode) begin
      if (idx == IDX_W'(IDX_PHASE_RD))
        rdData = phase;
      else if (idx == IDX_W'(IDX_HSHK_RD) && phase == PHASE_PRESENT)
        rdData = SENSE_BIT;
    end
  end

  p_legacy_rd_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !extMode |-> rdData == '0);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrWe |=> (modeBits & $past(wrData)) == '0);

  p_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.setWe |=> (modeBits & $past(wrData)) == $past(wrData));

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchWe |=> $stable(latchQ));

  p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.phaseWe |=> $stable(phase));

endmodule

// File: rtl/flop_regfront.sv
module flop_regfront
  import flopfront_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int IDX_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              extMode,
  output logic [7:0]        ctlLatches,
  output logic [7:0]        holdData,
  output logic [7:0]        holdMode,
  output logic [7:0]        modeBits
);

  localparam int IDX_W = ADDR_W - IDX_SHIFT;

  logic [IDX_W-1:0] idx;
  strobe_t          stb;

  assign idx = addr[ADDR_W-1:IDX_SHIFT];

  frontCtrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .idx     (idx),
    .wrData  (wrData),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .latchQ  (ctlLatches),
    .stb     (stb),
    .extMode (extMode)
  );

  frontData #(.IDX_W(IDX_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .idx      (idx),
    .extMode  (extMode),
    .latchQ   (ctlLatches),
    .holdData (holdData),
    .holdMode (holdMode),
    .modeBits (modeBits),
    .rdData   (rdData)
  );

endmodule

// File: tb/flop_regfront_tb.sv
`timescale 1ns/1ps
module flop_regfront_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  rdData, ctlLatches, holdData, holdMode, modeBits;
  logic        extMode;

  int errors = 0;
  int checks = 0;
  logic [7:0] lastRd;
  logic       extDuring;

  always #2.5 clk = ~clk;

  flop_regfront u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .extMode(extMode), .ctlLatches(ctlLatches),
    .holdData(holdData), .holdMode(holdMode), .modeBits(modeBits)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] at(input int idx, input int low = 0);
    return 13'((idx << 9) | (low & 9'h1FF));
  endfunction

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    #1 extDuring = extMode;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 lastRd = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R9 extMode", {7'd0, extMode}, 8'h00);
    chk("R9 latches", ctlLatches, 8'h00);
    chk("R9 holdData", holdData, 8'h00);
    chk("R9 holdMode", holdMode, 8'h00);
    chk("R9 modeBits", modeBits, 8'h00);
  endtask

  task automatic testLatches();
    wr(at(1), 8'hFF);
    chk("R2 write sets phase0", ctlLatches, 8'h01);
    rd(at(3));
    chk("R2 read sets phase1", ctlLatches, 8'h03);
    chk("R6 legacy read zero", lastRd, 8'h00);
    rd(at(0));
    chk("R2 read clears phase0", ctlLatches, 8'h02);
    rd(at(8'hB, 9'h1FF));
    chk("R1 low bits ignored, drive select", ctlLatches, 8'h22);
    chk("R3 no store without Q6/Q7", holdData | holdMode, 8'h00);
  endtask

  task automatic testHolders();
    rd(at(13));
    wr(at(13), 8'h11);
    chk("R3 Q7 clear no store", holdMode, 8'h00);
    rd(at(9));
    wr(at(15), 8'hA5);
    chk("R3 motor set -> data", holdData, 8'hA5);
    chk("R3 motor set mode untouched", holdMode, 8'h00);
    rd(at(8));
    wr(at(15), 8'h3C);
    chk("R3 motor clear -> mode", holdMode, 8'h3C);
    chk("R3 data kept", holdData, 8'hA5);
    rd(at(12));
    chk("R6 legacy read zero idx12", lastRd, 8'h00);
  endtask

  task automatic testUnlock();
    rd(at(13));
    wr(at(15), 8'h57);
    wr(at(15), 8'h00);
    wr(at(15), 8'h17);
    wr(at(15), 8'h57);
    wr(at(15), 8'h22);
    chk("R4 noise holds step, still legacy", {7'd0, extMode}, 8'h00);
    wr(at(15), 8'h57);
    chk("R5 legacy during final write", {7'd0, extDuring}, 8'h00);
    chk("R5 ext after final write", {7'd0, extMode}, 8'h01);
    chk("R4 mode holder last byte", holdMode, 8'h57);
  endtask

  task automatic testExtended();
    logic [7:0] latSnap;
    latSnap = ctlLatches;
    wr(at(4, 9'h1FF), 8'h77);
    rd(at(12));
    chk("R8 phase readback", lastRd, 8'h77);
    rd(at(15));
    chk("R8 handshake sense", lastRd, 8'h08);
    chk("R7 latches frozen", ctlLatches, latSnap);
    wr(at(4), 8'h76);
    rd(at(15));
    chk("R8 handshake no sense", lastRd, 8'h00);
    rd(at(13));
    chk("R8 other read zero", lastRd, 8'h00);
    wr(at(7), 8'hF0);
    chk("R7 set bits", modeBits, 8'hF0);
    wr(at(6), 8'h30);
    chk("R7 clear bits", modeBits, 8'hC0);
    wr(at(5), 8'hFF);
    wr(at(0), 8'hFF);
    wr(at(15), 8'h12);
    rd(at(12));
    chk("R7 ignored writes keep phase", lastRd, 8'h76);
    chk("R7 ignored writes keep mode", modeBits, 8'hC0);
    chk("R7 holders frozen", holdMode, 8'h57);
    chk("R5 still extended", {7'd0, extMode}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R9 reset extMode", {7'd0, extMode}, 8'h00);
    chk("R9 reset latches", ctlLatches, 8'h00);
    testLatches();
    testHolders();
    doReset();
    testUnlock();
    testExtended();
    doReset();
    rd(at(12));
    chk("R6 read zero after reset", lastRd, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule